// File: doc/BRIEF.md
# Byte-to-Word Burst DMA Funnel

This block moves a stream of bytes between a byte-wide device port and a 16-bit host bus, acting as a bus master for the host side. A 64-byte FIFO separates the two sides. Toward the host, bytes are joined into words. Toward the device, host words are split back into bytes.

Software loads a start address, a byte count and a direction, then pulses start. The block raises a bus request only when a full burst is ready: 32 buffered bytes going to the host, or 32 free bytes coming from the host. Once granted, it moves 16 words at one word per clock and then drops the request. Between bursts other masters can use the bus. When the device count runs out, any remaining words are flushed in a final short burst and a done flag is raised. A device-side overrun or underrun stops the transfer and sets a sticky error flag.

The byte count is taken as even: bit 0 of the count is dropped, so a transfer always moves whole words.

Top module: `byte_word_funnel`

## Requirements
- R1: After reset, busReq, hostCycle, busy, done and err are all 0.
- R2: The first host word of a transfer uses startAddr, and each following word uses the previous address plus 2, across burst boundaries.
- R3: With dirToHost=1, the first of each pair of device bytes lands in hostWData[15:8] and the second in hostWData[7:0].
- R4: With dirToHost=0, devDataOut shows the upper byte hostRData[15:8] of a host word first and its lower byte second, in host address order.
- R5: With dirToHost=1, busReq stays 0 while the FIFO holds fewer than 32 bytes and device bytes are still due. It rises once 32 bytes are held.
- R6: With dirToHost=0, busReq rises with no device activity while at least 32 bytes of the FIFO are free. The FIFO fills to its 64-byte capacity with two bursts.
- R7: busReq stays asserted until busGrant. A granted burst moves one word per clock in which hostAck is high, moves at most 16 words, and then drops busReq.
- R8: When the device side has moved its last byte, the words still owed move in a final burst shorter than 16 words. For a 100-byte transfer the bursts are 16, 16, 16 and 2 words.
- R9: When all bytes have crossed both ports, busy falls and done rises. A zero count completes with no bus request.
- R10: A device strobe while dirToHost=1 and the FIFO holds 64 bytes sets err, clears busy and drops busReq. err stays set until the next start, which clears it.
- R11: A device strobe while dirToHost=0 and the FIFO is empty sets err and clears busy.
- R12: The direction is captured only at start. Changing dirToHost during a transfer changes neither hostWrite nor the data flow.
- R13: Device strobes while no transfer is active move no data, cause no host cycle and leave err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle pulse that loads address, count and direction and clears the FIFO |
| dirToHost | input | 1 | 1 = device to host, 0 = host to device; sampled at start |
| startAddr | input | 24 | Host byte address of the first word |
| byteCount | input | 16 | Bytes to transfer; bit 0 is ignored |
| devStrobe | input | 1 | Device moves one byte this cycle |
| devDataIn | input | 8 | Device byte written into the FIFO (device to host) |
| devDataOut | output | 8 | Head byte of the FIFO for the device (host to device) |
| busReq | output | 1 | Host bus request |
| busGrant | input | 1 | Host bus grant |
| hostCycle | output | 1 | A word cycle is active on the host bus |
| hostAck | input | 1 | Host completes the current word cycle |
| hostWrite | output | 1 | 1 = block writes to host memory |
| hostAddr | output | 24 | Host byte address of the current word |
| hostWData | output | 16 | Word written to the host |
| hostRData | input | 16 | Word read from the host |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed normally |
| err | output | 1 | Sticky overrun or underrun flag |

## Verification
A device strobe takes effect at the next rising edge. A request raised by that byte appears one edge later, because the burst decision is made on the registered fill level. A grant seen on one edge puts the word cycle on the bus from the following edge onward, and each word moves on the edge at which hostCycle and hostAck are both high. The bench drives all inputs and samples all outputs on the falling edge. A monitor compares every host word, address and burst length against a queue filled by the drivers, so each result is checked in the cycle it is due. Status checks after a stimulus wait at least two falling edges, which covers the single register between a strobe and err, done or busy.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clear;     // empty the FIFO
    logic devPush;   // one device byte in
    logic devPop;    // one device byte out
    logic hostPush;  // one host word in (two bytes)
    logic hostPop;   // one host word out (two bytes)
    logic loadAddr;  // load the host address counter
    logic stepAddr;  // advance the host address by one word
  } fifoStrobe_t;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_REQ  = 2'd1,
    BUS_XFER = 2'd2
  } busState_t;

endpackage

// File: rtl/funnel_datapath.sv
module funnel_datapath import funnel_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fifoStrobe_t             ctl,
  input  logic [7:0]              devDataIn,
  input  logic [15:0]             hostRData,
  input  logic [ADDR_W-1:0]       startAddr,
  output logic [$clog2(DEPTH):0]  fill,
  output logic [7:0]              devDataOut,
  output logic [15:0]             hostWData,
  output logic [ADDR_W-1:0]       hostAddr
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int FW    = PTR_W + 1;

  logic [7:0]        memQ [DEPTH];
  logic [PTR_W-1:0]  wrPtrQ, rdPtrQ, wrNext, rdNext;
  logic [FW-1:0]     fillQ, pushN, popN;
  logic [ADDR_W-1:0] addrQ;

  assign wrNext = wrPtrQ + PTR_W'(1);
  assign rdNext = rdPtrQ + PTR_W'(1);

  always_comb begin
    pushN = '0;
    if (ctl.devPush)       pushN = FW'(1);
    else if (ctl.hostPush) pushN = FW'(2);
    popN = '0;
    if (ctl.devPop)        popN = FW'(1);
    else if (ctl.hostPop)  popN = FW'(2);
  end

  // byte storage; a host word writes its upper byte first in FIFO order
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ctl.devPush && wrPtrQ == PTR_W'(i))       memQ[i] <= devDataIn;
        else if (ctl.hostPush && wrPtrQ == PTR_W'(i)) memQ[i] <= hostRData[15:8];
        else if (ctl.hostPush && wrNext == PTR_W'(i)) memQ[i] <= hostRData[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      fillQ  <= '0;
    end else if (ctl.clear) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
      fillQ  <= '0;
    end else begin
      if (ctl.devPush)       wrPtrQ <= wrNext;
      else if (ctl.hostPush) wrPtrQ <= wrPtrQ + PTR_W'(2);
      if (ctl.devPop)        rdPtrQ <= rdNext;
      else if (ctl.hostPop)  rdPtrQ <= rdPtrQ + PTR_W'(2);
      fillQ <= fillQ + pushN - popN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrQ <= '0;
    else if (ctl.loadAddr) addrQ <= startAddr;
    else if (ctl.stepAddr) addrQ <= addrQ + ADDR_W'(2);
  end

  assign fill       = fillQ;
  assign devDataOut = memQ[rdPtrQ];
  assign hostWData  = {memQ[rdPtrQ], memQ[rdNext]};
  assign hostAddr   = addrQ;

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillQ <= FW'(DEPTH));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.devPush && fillQ == FW'(DEPTH)));

  // R11
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.devPop && fillQ == '0));

  // R3
  host_pop_whole_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hostPop |-> (fillQ >= FW'(2)));

endmodule

// File: rtl/funnel_control.sv
module funnel_control import funnel_pkg::*; #(
  parameter int DEPTH       = 64,
  parameter int BURST_WORDS = 16,
  parameter int CNT_W       = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  input  logic                    dirToHost,
  input  logic [CNT_W-1:0]        byteCount,
  input  logic                    devStrobe,
  input  logic [$clog2(DEPTH):0]  fill,
  input  logic                    busGrant,
  input  logic                    hostAck,
  output fifoStrobe_t             ctl,
  output logic                    busReq,
  output logic                    hostCycle,
  output logic                    hostWrite,
  output logic                    busy,
  output logic                    done,
  output logic                    err
);

  localparam int FW     = $clog2(DEPTH) + 1;
  localparam int THRESH = 2 * BURST_WORDS;
  localparam int BL_W   = $clog2(BURST_WORDS + 1);

  busState_t        stateQ;
  logic             dirQ, busyQ, doneQ, errQ;
  logic [CNT_W-1:0] devRemainQ, hostRemainQ;
  logic [BL_W-1:0]  burstLeftQ, firstLen;
  logic [FW-1:0]    freeBytes;
  logic active, devWant, pushOk, popOk, overflow, underflow, fault;
  logic wordMove, burstReady;

  always_comb begin
    active    = busyQ && !startPulse;
    devWant   = active && devStrobe && (devRemainQ != '0);
    pushOk    = devWant && dirQ && (fill != FW'(DEPTH));
    overflow  = devWant && dirQ && (fill == FW'(DEPTH));
    popOk     = devWant && !dirQ && (fill != '0);
    underflow = devWant && !dirQ && (fill == '0);
    fault     = overflow || underflow;
    wordMove  = active && (stateQ == BUS_XFER) && busGrant && hostAck;
    freeBytes = FW'(DEPTH) - fill;
    burstReady = active && !fault && (hostRemainQ != '0) &&
                 (dirQ ? ((fill >= FW'(THRESH)) || (devRemainQ == '0))
                       : (freeBytes >= FW'(THRESH)));
    firstLen  = (hostRemainQ > CNT_W'(BURST_WORDS)) ? BL_W'(BURST_WORDS)
                                                    : BL_W'(hostRemainQ);

    ctl.clear    = startPulse;
    ctl.loadAddr = startPulse;
    ctl.devPush  = pushOk;
    ctl.devPop   = popOk;
    ctl.hostPop  = wordMove && dirQ;
    ctl.hostPush = wordMove && !dirQ;
    ctl.stepAddr = wordMove;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= BUS_IDLE;
      dirQ        <= 1'b0;
      busyQ       <= 1'b0;
      doneQ       <= 1'b0;
      errQ        <= 1'b0;
      devRemainQ  <= '0;
      hostRemainQ <= '0;
      burstLeftQ  <= '0;
    end else if (startPulse) begin
      stateQ      <= BUS_IDLE;
      dirQ        <= dirToHost;
      busyQ       <= 1'b1;
      doneQ       <= 1'b0;
      errQ        <= 1'b0;
      devRemainQ  <= {byteCount[CNT_W-1:1], 1'b0};
      hostRemainQ <= byteCount >> 1;
      burstLeftQ  <= '0;
    end else if (busyQ) begin
      if (fault) begin
        errQ   <= 1'b1;
        busyQ  <= 1'b0;
        stateQ <= BUS_IDLE;
      end else begin
        if (pushOk || popOk) devRemainQ  <= devRemainQ - CNT_W'(1);
        if (wordMove)        hostRemainQ <= hostRemainQ - CNT_W'(1);
        unique case (stateQ)
          BUS_IDLE: if (burstReady) begin
            stateQ     <= BUS_REQ;
            burstLeftQ <= firstLen;
          end
          BUS_REQ:  if (busGrant) stateQ <= BUS_XFER;
          BUS_XFER: if (wordMove) begin
            burstLeftQ <= burstLeftQ - BL_W'(1);
            if (burstLeftQ == BL_W'(1)) stateQ <= BUS_IDLE;
          end
          default:  stateQ <= BUS_IDLE;
        endcase
        if (devRemainQ == '0 && hostRemainQ == '0) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  assign busReq    = busyQ && (stateQ != BUS_IDLE);
  assign hostCycle = busyQ && (stateQ == BUS_XFER) && busGrant;
  assign hostWrite = dirQ;
  assign busy      = busyQ;
  assign done      = doneQ;
  assign err       = errQ;

  // words seen inside the current request, for the burst length check
  logic [BL_W:0] burstWordsQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         burstWordsQ <= '0;
    else if (!busReq)  burstWordsQ <= '0;
    else if (wordMove) burstWordsQ <= burstWordsQ + (BL_W+1)'(1);
  end

  // R7
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstWordsQ <= (BL_W+1)'(BURST_WORDS));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == BUS_REQ && busyQ && !busGrant && !startPulse && !fault) |=> busReq);

  // R7
  cycle_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostCycle |-> busReq);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !startPulse) |=> errQ);

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> !busReq);

  // R9
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && busyQ));

endmodule

// File: rtl/byte_word_funnel.sv
module byte_word_funnel import funnel_pkg::*; #(
  parameter int DEPTH       = 64,
  parameter int BURST_WORDS = 16,
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              dirToHost,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              devStrobe,
  input  logic [7:0]        devDataIn,
  output logic [7:0]        devDataOut,
  output logic              busReq,
  input  logic              busGrant,
  output logic              hostCycle,
  input  logic              hostAck,
  output logic              hostWrite,
  output logic [ADDR_W-1:0] hostAddr,
  output logic [15:0]       hostWData,
  input  logic [15:0]       hostRData,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int FW = $clog2(DEPTH) + 1;

  fifoStrobe_t   ctl;
  logic [FW-1:0] fill;

  funnel_control #(
    .DEPTH(DEPTH), .BURST_WORDS(BURST_WORDS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .dirToHost(dirToHost),
    .byteCount(byteCount), .devStrobe(devStrobe), .fill(fill),
    .busGrant(busGrant), .hostAck(hostAck), .ctl(ctl), .busReq(busReq),
    .hostCycle(hostCycle), .hostWrite(hostWrite), .busy(busy),
    .done(done), .err(err)
  );

  funnel_datapath #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .devDataIn(devDataIn),
    .hostRData(hostRData), .startAddr(startAddr), .fill(fill),
    .devDataOut(devDataOut), .hostWData(hostWData), .hostAddr(hostAddr)
  );

endmodule

// File: tb/byte_word_funnel_tb.sv
module byte_word_funnel_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        dirToHost = 1'b0;
  logic [23:0] startAddr = '0;
  logic [15:0] byteCount = '0;
  logic        devStrobe = 1'b0;
  logic [7:0]  devDataIn = '0;
  logic        busGrant = 1'b0;
  logic        hostAck = 1'b0;
  logic [15:0] hostRData = '0;
  logic [7:0]  devDataOut;
  logic        busReq, hostCycle, hostWrite, busy, done, err;
  logic [23:0] hostAddr;
  logic [15:0] hostWData;

  byte_word_funnel u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .dirToHost(dirToHost),
    .startAddr(startAddr), .byteCount(byteCount), .devStrobe(devStrobe),
    .devDataIn(devDataIn), .devDataOut(devDataOut), .busReq(busReq),
    .busGrant(busGrant), .hostCycle(hostCycle), .hostAck(hostAck),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWData(hostWData),
    .hostRData(hostRData), .busy(busy), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0;
  int          fails = 0;
  logic [15:0] wordQ[$];
  int          burstQ[$];
  logic [23:0] expAddr = '0;
  int          totalWords = 0;
  int          curBurst = 0;
  bit          grantEnable = 1'b0;
  bit          modeD2h = 1'b0;
  bit          havePend = 1'b0;
  logic [7:0]  pendHi = '0;

  function automatic logic [15:0] memWord(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[8:1] + 8'h3C};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // host bus model and scoreboard monitor
  initial begin
    int          reqAge;
    bit          prevReq;
    logic [15:0] expW;
    reqAge = 0;
    prevReq = 1'b0;
    forever begin
      @(negedge clk);
      if (busReq) reqAge++; else reqAge = 0;
      busGrant  = busReq && grantEnable && (reqAge >= 2);
      hostAck   = busGrant;
      hostRData = memWord(hostAddr);
      #1;
      if (hostCycle && hostAck) begin
        totalWords++;
        curBurst++;
        check(hostAddr == expAddr, "R2 host address", 32'(hostAddr), 32'(expAddr));
        expAddr = expAddr + 24'd2;
        if (modeD2h) begin
          if (wordQ.size() == 0) check(1'b0, "R3 unexpected host word", 32'(hostWData), 0);
          else begin
            expW = wordQ.pop_front();
            check(hostWData == expW, "R3 packed word", 32'(hostWData), 32'(expW));
          end
        end
      end
      if (prevReq && !busReq) begin
        burstQ.push_back(curBurst);
        curBurst = 0;
      end
      prevReq = busReq;
    end
  end

  task automatic startXfer(input bit dir, input logic [23:0] addr, input logic [15:0] cnt);
    @(negedge clk);
    wordQ.delete();
    burstQ.delete();
    havePend = 1'b0;
    curBurst = 0;
    expAddr = addr;
    modeD2h = dir;
    startPulse = 1'b1;
    dirToHost = dir;
    startAddr = addr;
    byteCount = cnt;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // device byte toward the host; every second byte completes an expected word
  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    devStrobe = 1'b1;
    devDataIn = b;
    if (havePend) wordQ.push_back({pendHi, b});
    else pendHi = b;
    havePend = !havePend;
    @(negedge clk);
    devStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic popByte(input logic [7:0] exp);
    @(negedge clk);
    check(devDataOut == exp, "R4 unpacked byte", 32'(devDataOut), 32'(exp));
    devStrobe = 1'b1;
    @(negedge clk);
    devStrobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
  endtask

  task automatic checkBursts(input string tag, input int n, input int lastLen);
    check(burstQ.size() == n, tag, 32'(burstQ.size()), 32'(n));
    for (int i = 0; i < burstQ.size(); i++) begin
      int expLen;
      expLen = (i == n - 1) ? lastLen : 16;
      check(burstQ[i] == expLen, tag, 32'(burstQ[i]), 32'(expLen));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busReq, hostCycle, busy, done, err} == 5'b0, "R1 reset outputs",
          32'({busReq, hostCycle, busy, done, err}), 0);

    // device to host, 100 bytes
    grantEnable = 1'b0;
    base = totalWords;
    startXfer(1'b1, 24'h001000, 16'd100);
    dirToHost = 1'b0;  // R12: must not matter after start
    for (int i = 0; i < 31; i++) pushByte(8'(i * 7 + 3));
    repeat (4) @(negedge clk);
    check(busReq == 1'b0, "R5 no request below threshold", 32'(busReq), 0);
    pushByte(8'(31 * 7 + 3));
    check(busReq == 1'b1, "R5 request at threshold", 32'(busReq), 1);
    repeat (6) @(negedge clk);
    check(busReq == 1'b1, "R7 request held until grant", 32'(busReq), 1);
    check(totalWords == base, "R7 no word before grant", 32'(totalWords - base), 0);
    check(hostWrite == 1'b1, "R12 direction latched", 32'(hostWrite), 1);
    grantEnable = 1'b1;
    for (int i = 32; i < 100; i++) pushByte(8'(i * 7 + 3));
    waitDone();
    repeat (2) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0 && err == 1'b0, "R9 done after transfer",
          32'({done, busy, err}), 32'(3'b100));
    check(totalWords - base == 50, "R8 all words flushed", 32'(totalWords - base), 50);
    check(wordQ.size() == 0, "R3 every packed word delivered", 32'(wordQ.size()), 0);
    checkBursts("R8 burst lengths 16,16,16,2", 4, 2);

    // R13 strobes with no active transfer
    base = totalWords;
    for (int i = 0; i < 3; i++) pushByte(8'hEE);
    repeat (5) @(negedge clk);
    check(totalWords == base && busReq == 1'b0, "R13 idle strobes ignored",
          32'(totalWords - base), 0);
    check(err == 1'b0 && done == 1'b1, "R13 idle strobes leave status",
          32'({err, done}), 32'(2'b01));

    // host to device, 100 bytes
    grantEnable = 1'b1;
    base = totalWords;
    startXfer(1'b0, 24'h002040, 16'd100);
    repeat (60) @(negedge clk);
    check(totalWords - base == 32, "R6 prefill to capacity", 32'(totalWords - base), 32);
    check(hostWrite == 1'b0, "R6 read direction", 32'(hostWrite), 0);
    checkBursts("R7 two full prefill bursts", 2, 16);
    for (int k = 0; k < 100; k++) begin
      logic [15:0] w;
      w = memWord(24'h002040 + 24'(2 * (k / 2)));
      popByte((k % 2 == 0) ? w[15:8] : w[7:0]);
    end
    waitDone();
    repeat (2) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0 && err == 1'b0, "R9 read transfer done",
          32'({done, busy, err}), 32'(3'b100));
    check(totalWords - base == 50, "R8 read words moved", 32'(totalWords - base), 50);
    checkBursts("R8 read burst lengths 16,16,16,2", 4, 2);

    // overflow
    grantEnable = 1'b0;
    startXfer(1'b1, 24'h003000, 16'd200);
    for (int i = 0; i < 64; i++) pushByte(8'(i));
    check(err == 1'b0, "R10 full FIFO alone is no error", 32'(err), 0);
    pushByte(8'h55);
    check(err == 1'b1 && busy == 1'b0, "R10 overflow sets err", 32'({err, busy}), 32'(2'b10));
    check(busReq == 1'b0, "R10 request dropped on error", 32'(busReq), 0);
    repeat (5) @(negedge clk);
    check(err == 1'b1, "R10 err sticky", 32'(err), 1);

    // underflow
    startXfer(1'b0, 24'h004000, 16'd100);
    check(err == 1'b0 && busy == 1'b1, "R10 start clears err", 32'({err, busy}), 32'(2'b01));
    @(negedge clk);
    devStrobe = 1'b1;
    @(negedge clk);
    devStrobe = 1'b0;
    @(negedge clk);
    check(err == 1'b1 && busy == 1'b0, "R11 underflow sets err", 32'({err, busy}), 32'(2'b10));

    // zero count
    grantEnable = 1'b1;
    startXfer(1'b1, 24'h005000, 16'd0);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && busReq == 1'b0 && err == 1'b0, "R9 zero count completes",
          32'({done, busReq, err}), 32'(3'b100));

    finishRun();
  end

endmodule